// File: doc/BRIEF.md
# Video Capture Window Controller

The block sits behind a video input port and decides which incoming pixels belong to the capture window. It follows vertical sync, horizontal sync and a field-ID input. It counts lines from the active vertical sync edge and counts pixels from the active horizontal sync edge. It raises a data-valid strobe for each pixel that falls inside the programmed rectangle. A memory writer downstream stores only the strobed pixels.

The window is programmed in cells, not in pixels. A cell holds one pixel in raw capture and two samples (luma plus chroma) in YCbCr capture, and the horizontal values are scaled to match. The first line after vertical sync never carries data, so the vertical start is always shifted down by one line. In interlaced mode the vertical start and the height are halved, because each field holds half the lines. Two vertical interrupt pulses mark the first window line and, in progressive frames only, the middle of the image. The field ID is captured at each vertical sync.

One pixel arrives per clock cycle. The configuration inputs are expected to stay still while a frame is being captured.

Top module: `capture_window`

## Requirements
- R1: While rst_n is low, data_valid, vint0, vint1 and field_id are all 0.
- R2: After an active horizontal sync edge, the next pixel is index 0. With two_per_cell = 0, data_valid is high for pixel indices win_left through win_left + win_width - 1, inclusive, on window lines.
- R3: With two_per_cell = 1, the horizontal window covers pixel indices 2*win_left through 2*win_left + 2*win_width - 1, inclusive.
- R4: The line number is 0 after an active vertical sync edge and rises by one at each active horizontal sync edge. With interlaced = 0, window lines run from win_top + 1 through win_top + win_height, inclusive.
- R5: With interlaced = 1, window lines run from (win_top >> 1) + 1 through (win_top >> 1) + (win_height >> 1), inclusive.
- R6: vint0 is a one-cycle pulse in the cycle where the line number has just become the first window line. That cycle is the one in which pixel index 0 of that line is presented.
- R7: With interlaced = 0, vint1 pulses for one cycle when the line number becomes the first window line plus (win_height >> 1). With interlaced = 1, vint1 stays 0.
- R8: A polarity input of 1 makes the falling edge of its sync input the active edge (and a low level the active level). A polarity input of 0 selects the rising edge. vs_pol_neg, hs_pol_neg and fid_pol_neg act independently.
- R9: field_id takes the field input's active level (fid_in XOR fid_pol_neg) at each active vertical sync edge. It holds that value until the next such edge, whatever fid_in does in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, one pixel per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_in | input | 1 | Vertical sync |
| hsync_in | input | 1 | Horizontal sync |
| fid_in | input | 1 | Field identifier |
| vs_pol_neg | input | 1 | 1: vertical sync active low |
| hs_pol_neg | input | 1 | 1: horizontal sync active low |
| fid_pol_neg | input | 1 | 1: field input inverted |
| interlaced | input | 1 | 1: interlaced frame format |
| two_per_cell | input | 1 | 1: two pixels per cell (YCbCr) |
| win_left | input | PIX_W | Left edge, in cells |
| win_width | input | PIX_W | Width, in cells, at least 1 |
| win_top | input | LINE_W | Top edge, in frame lines |
| win_height | input | LINE_W | Height, in frame lines |
| data_valid | output | 1 | Pixel lies inside the window |
| vint0 | output | 1 | Pulse at the first window line |
| vint1 | output | 1 | Pulse at the mid-image line |
| field_id | output | 1 | Field ID captured at the last vertical sync |

## Verification
The line or pixel counter can lose its place, for example through a missed sync edge or a counter that wraps. When that happens, data_valid moves by whole lines or by whole pixels, and the error first appears at the next window edge of the same line or frame. It then persists until the next sync edge of that kind resets the counter.

A window start that is off by one shows up as a strobe that is one pixel or one line too early or too late. The interrupt pulses also move with it, because they use the same line count. A field register that reloads without a sync edge changes field_id in the middle of a frame, and this is visible as soon as fid_in toggles.

// File: rtl/cw_pkg.sv
package cw_pkg;
  typedef enum logic {
    FMT_PROG = 1'b0,
    FMT_INTL = 1'b1
  } frame_fmt_e;

  // Active level of a sync input after polarity selection.
  function automatic logic active_level(input logic raw, input logic pol_neg);
    return raw ^ pol_neg;
  endfunction
endpackage

// File: rtl/cw_sync_edge.sv
module cw_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  input  logic pol_neg,
  output logic edge_o
);
  logic lvl;
  logic lvl_q;

  assign lvl    = cw_pkg::active_level(sig_in, pol_neg);
  assign edge_o = lvl & ~lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end
endmodule

// File: rtl/cw_geometry.sv
module cw_geometry #(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 11
) (
  input  logic              interlaced,
  input  logic              two_per_cell,
  input  logic [PIX_W-1:0]  win_left,
  input  logic [PIX_W-1:0]  win_width,
  input  logic [LINE_W-1:0] win_top,
  input  logic [LINE_W-1:0] win_height,
  output logic [PIX_W-1:0]  h_first,
  output logic [PIX_W-1:0]  h_last,
  output logic [LINE_W-1:0] v_first,
  output logic [LINE_W-1:0] v_last,
  output logic [LINE_W-1:0] v_mid,
  output logic              mid_en
);
  import cw_pkg::*;
  localparam logic [PIX_W-1:0]  PIX_ONE  = PIX_W'(1);
  localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);

  frame_fmt_e        fmt;
  logic [PIX_W-1:0]  h_span;
  logic [LINE_W-1:0] v_rows;

  always_comb begin
    fmt = interlaced ? FMT_INTL : FMT_PROG;
    if (two_per_cell) begin
      h_first = {win_left[PIX_W-2:0], 1'b0};
      h_span  = {win_width[PIX_W-2:0], 1'b0};
    end else begin
      h_first = win_left;
      h_span  = win_width;
    end
    h_last = h_first + h_span - PIX_ONE;
    if (fmt == FMT_INTL) begin
      v_first = (win_top >> 1) + LINE_ONE;
      v_rows  = win_height >> 1;
      mid_en  = 1'b0;
    end else begin
      v_first = win_top + LINE_ONE;
      v_rows  = win_height;
      mid_en  = 1'b1;
    end
    v_last = v_first + v_rows - LINE_ONE;
    v_mid  = v_first + (win_height >> 1);
  end
endmodule

// File: rtl/cw_position.sv
module cw_position #(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vs_edge,
  input  logic              hs_edge,
  output logic [PIX_W-1:0]  pix_cnt,
  output logic [LINE_W-1:0] line_cnt,
  output logic [LINE_W-1:0] line_inc
);
  localparam logic [PIX_W-1:0]  PIX_MAX  = '1;
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic [PIX_W-1:0]  pix_d;
  logic [LINE_W-1:0] line_d;

  always_comb begin
    line_inc = (line_cnt == LINE_MAX) ? line_cnt : line_cnt + 1'b1;
    if (hs_edge)                pix_d = '0;
    else if (pix_cnt == PIX_MAX) pix_d = pix_cnt;
    else                        pix_d = pix_cnt + 1'b1;
    if (vs_edge)      line_d = '0;
    else if (hs_edge) line_d = line_inc;
    else              line_d = line_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_cnt  <= '0;
      line_cnt <= '0;
    end else begin
      pix_cnt  <= pix_d;
      line_cnt <= line_d;
    end
  end
endmodule

// File: rtl/capture_window.sv
module capture_window #(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync_in,
  input  logic              hsync_in,
  input  logic              fid_in,
  input  logic              vs_pol_neg,
  input  logic              hs_pol_neg,
  input  logic              fid_pol_neg,
  input  logic              interlaced,
  input  logic              two_per_cell,
  input  logic [PIX_W-1:0]  win_left,
  input  logic [PIX_W-1:0]  win_width,
  input  logic [LINE_W-1:0] win_top,
  input  logic [LINE_W-1:0] win_height,
  output logic              data_valid,
  output logic              vint0,
  output logic              vint1,
  output logic              field_id
);
  localparam int NSYNC = 2;

  logic [NSYNC-1:0] sync_raw, sync_pol, sync_edge;
  logic             vs_edge, hs_edge;

  assign sync_raw = {hsync_in, vsync_in};
  assign sync_pol = {hs_pol_neg, vs_pol_neg};

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    cw_sync_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_in (sync_raw[g]),
      .pol_neg(sync_pol[g]),
      .edge_o (sync_edge[g])
    );
  end

  assign vs_edge = sync_edge[0];
  assign hs_edge = sync_edge[1];

  logic [PIX_W-1:0]  h_first, h_last;
  logic [LINE_W-1:0] v_first, v_last, v_mid;
  logic              mid_en;

  cw_geometry #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_geom (
    .interlaced  (interlaced),
    .two_per_cell(two_per_cell),
    .win_left    (win_left),
    .win_width   (win_width),
    .win_top     (win_top),
    .win_height  (win_height),
    .h_first     (h_first),
    .h_last      (h_last),
    .v_first     (v_first),
    .v_last      (v_last),
    .v_mid       (v_mid),
    .mid_en      (mid_en)
  );

  logic [PIX_W-1:0]  pix_cnt;
  logic [LINE_W-1:0] line_cnt, line_inc;

  cw_position #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_pos (
    .clk     (clk),
    .rst_n   (rst_n),
    .vs_edge (vs_edge),
    .hs_edge (hs_edge),
    .pix_cnt (pix_cnt),
    .line_cnt(line_cnt),
    .line_inc(line_inc)
  );

  logic line_step, vint0_d, vint1_d, field_d;

  always_comb begin
    line_step = hs_edge & ~vs_edge;
    vint0_d   = line_step & (line_inc == v_first);
    vint1_d   = line_step & mid_en & (line_inc == v_mid);
    field_d   = vs_edge ? cw_pkg::active_level(fid_in, fid_pol_neg) : field_id;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vint0    <= 1'b0;
      vint1    <= 1'b0;
      field_id <= 1'b0;
    end else begin
      vint0    <= vint0_d;
      vint1    <= vint1_d;
      field_id <= field_d;
    end
  end

  assign data_valid = (line_cnt >= v_first) && (line_cnt <= v_last) &&
                      (pix_cnt >= h_first) && (pix_cnt <= h_last);
endmodule

// File: rtl/cw_checker.sv
module cw_checker #(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vs_edge,
  input logic              hs_edge,
  input logic [PIX_W-1:0]  pix_cnt,
  input logic [LINE_W-1:0] line_cnt,
  input logic              interlaced,
  input logic              vint0,
  input logic              vint1,
  input logic              field_id
);
  p_pix_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hs_edge |=> (pix_cnt == '0));

  p_line_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vs_edge |=> (line_cnt == '0));

  p_vint0_at_pix0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vint0 |-> (pix_cnt == '0));

  p_vint0_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vint0 |=> !vint0);

  p_vint1_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (interlaced && $past(interlaced)) |-> !vint1);

  p_field_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_edge |=> $stable(field_id));
endmodule

bind capture_window cw_checker #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .vs_edge   (vs_edge),
  .hs_edge   (hs_edge),
  .pix_cnt   (pix_cnt),
  .line_cnt  (line_cnt),
  .interlaced(interlaced),
  .vint0     (vint0),
  .vint1     (vint1),
  .field_id  (field_id)
);

// File: tb/capture_window_tb.sv
module capture_window_tb;
  localparam int PIX_W  = 12;
  localparam int LINE_W = 11;

  logic clk = 1'b0;
  logic rst_n;
  logic vsync_in, hsync_in, fid_in;
  logic vs_pol_neg, hs_pol_neg, fid_pol_neg, interlaced, two_per_cell;
  logic [PIX_W-1:0]  win_left, win_width;
  logic [LINE_W-1:0] win_top, win_height;
  logic data_valid, vint0, vint1, field_id;

  always #5 clk = ~clk;

  capture_window #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .hsync_in(hsync_in),
    .fid_in(fid_in), .vs_pol_neg(vs_pol_neg), .hs_pol_neg(hs_pol_neg),
    .fid_pol_neg(fid_pol_neg), .interlaced(interlaced),
    .two_per_cell(two_per_cell), .win_left(win_left), .win_width(win_width),
    .win_top(win_top), .win_height(win_height), .data_valid(data_valid),
    .vint0(vint0), .vint1(vint1), .field_id(field_id)
  );

  typedef struct {
    bit    dv;
    bit    v0;
    bit    v1;
    bit    fid;
    string tag;
  } item_t;

  item_t sb[$];
  int    checks = 0;
  int    errors = 0;
  string cur_tag = "R1";

  // configuration requested by the test, applied at the next drive edge
  bit c_vpol, c_hpol, c_fpol, c_intl, c_two;
  int c_left, c_width, c_top, c_height;

  // bench-side position state
  int m_line, m_pix;
  bit m_vprev, m_hprev, m_field;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit v, input bit h, input bit f);
    item_t it;
    bit vedge, hedge;
    int hf, hl, vf, vl, vm;
    @(negedge clk);
    vs_pol_neg   = c_vpol;  hs_pol_neg = c_hpol;  fid_pol_neg = c_fpol;
    interlaced   = c_intl;  two_per_cell = c_two;
    win_left     = PIX_W'(c_left);  win_width  = PIX_W'(c_width);
    win_top      = LINE_W'(c_top);  win_height = LINE_W'(c_height);
    vsync_in = v ^ c_vpol;  hsync_in = h ^ c_hpol;  fid_in = f ^ c_fpol;
    // window bounds from the requirement formulas
    hf = c_two ? 2 * c_left : c_left;
    hl = hf + (c_two ? 2 * c_width : c_width) - 1;
    if (c_intl) begin
      vf = c_top / 2 + 1;
      vl = c_top / 2 + c_height / 2;
    end else begin
      vf = c_top + 1;
      vl = c_top + c_height;
    end
    vm = vf + c_height / 2;
    vedge = v && !m_vprev;
    hedge = h && !m_hprev;
    m_vprev = v;  m_hprev = h;
    if (vedge)      m_line = 0;
    else if (hedge) m_line++;
    if (hedge) m_pix = 0;
    else       m_pix++;
    if (vedge) m_field = f;
    it.dv  = (m_line >= vf) && (m_line <= vl) && (m_pix >= hf) && (m_pix <= hl);
    it.v0  = hedge && !vedge && (m_line == vf);
    it.v1  = !c_intl && hedge && !vedge && (m_line == vm);
    it.fid = m_field;
    it.tag = cur_tag;
    sb.push_back(it);
  endtask

  task automatic frame(input int nlines, input int llen, input bit f_vs, input bit f_after);
    cyc(1'b1, 1'b0, f_vs);
    cyc(1'b0, 1'b0, f_vs);
    for (int l = 0; l < nlines; l++) begin
      cyc(1'b0, 1'b1, f_after);
      for (int p = 1; p < llen; p++) cyc(1'b0, 1'b0, f_after);
    end
  endtask

  // monitor: compare design outputs against queued expectations
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        check(it.tag, "data_valid", int'(data_valid), int'(it.dv));
        check(it.tag, "vint0",      int'(vint0),      int'(it.v0));
        check(it.tag, "vint1",      int'(vint1),      int'(it.v1));
        check(it.tag, "field_id",   int'(field_id),   int'(it.fid));
      end
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    vsync_in = 1'b0; hsync_in = 1'b0; fid_in = 1'b1;
    vs_pol_neg = 1'b0; hs_pol_neg = 1'b0; fid_pol_neg = 1'b0;
    interlaced = 1'b0; two_per_cell = 1'b0;
    win_left = '0; win_width = PIX_W'(4); win_top = '0; win_height = LINE_W'(4);
    c_vpol = 0; c_hpol = 0; c_fpol = 0; c_intl = 0; c_two = 0;
    c_left = 0; c_width = 4; c_top = 0; c_height = 4;
    m_line = 0; m_pix = 0; m_vprev = 0; m_hprev = 0; m_field = 0;

    // R1: outputs held low in reset, even with sync toggling
    repeat (2) @(negedge clk);
    vsync_in = 1'b1; hsync_in = 1'b1;
    @(negedge clk);
    check("R1", "data_valid", int'(data_valid), 0);
    check("R1", "vint0",      int'(vint0),      0);
    check("R1", "vint1",      int'(vint1),      0);
    check("R1", "field_id",   int'(field_id),   0);
    vsync_in = 1'b0; hsync_in = 1'b0; fid_in = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R4 R6 R7: raw cells, progressive frame
    cur_tag = "R2 R4 R6 R7";
    c_left = 3; c_width = 4; c_top = 2; c_height = 6;
    frame(12, 16, 1'b0, 1'b0);

    // R3 R4 R6 R7: two pixels per cell, window at the top edge
    cur_tag = "R3 R4 R6 R7";
    c_two = 1; c_left = 2; c_width = 3; c_top = 0; c_height = 3;
    frame(6, 16, 1'b0, 1'b0);

    // R5 R7 R9: interlaced field, field input changes after sync
    cur_tag = "R5 R7 R9";
    c_two = 0; c_intl = 1; c_left = 0; c_width = 2; c_top = 5; c_height = 8;
    frame(9, 8, 1'b1, 1'b0);

    // R5 R9: next field picks up the new field input
    cur_tag = "R5 R9";
    c_top = 4; c_height = 6;
    frame(6, 8, 1'b0, 1'b1);

    // R8: all polarities negative, falling edges active
    cur_tag = "R8 R9";
    c_vpol = 1; c_hpol = 1; c_fpol = 1; c_intl = 0;
    c_left = 1; c_width = 5; c_top = 1; c_height = 4;
    cyc(1'b0, 1'b0, 1'b0);
    frame(8, 10, 1'b1, 1'b0);

    // R8: mixed polarities, window at pixel 0
    cur_tag = "R8 R2 R6";
    c_vpol = 0; c_hpol = 1; c_fpol = 0;
    cyc(1'b0, 1'b0, 1'b0);
    c_left = 0; c_width = 3; c_top = 3; c_height = 2;
    frame(7, 6, 1'b0, 1'b1);

    repeat (4) cyc(1'b0, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    #3;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule